// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block chooses which of seven interrupt request flags a small 8-bit controller core services next, and it tracks how deeply the core is nested in service routines. Each source can be masked on its own or together with the others through a global enable, and each source is given one of two priority levels. At every machine-cycle strobe the block captures the flags. At the following strobe it arbitrates on that captured copy. When a source wins, it raises a request with the source's vector address and holds it until the core reports that it has taken the vector.

The request flags themselves live in the peripherals. When the core takes a vector, the block issues a one-clock clear pulse for the flags that hardware clears on acknowledge. The core sends a return pulse at the end of each service routine, and this pulse unwinds one nesting level. A low-level routine can be preempted by a high-level request. A high-level routine cannot be preempted by anything. The block keeps no record of a request that was blocked: if the flag has gone by the next capture, the request is lost.

The flag, enable and priority vectors share one bit order, which is also the fixed polling order, highest first:

| Bit | Source |
|-----|--------|
| 0 | external request 0 |
| 1 | timer 0 |
| 2 | external request 1 |
| 3 | timer 1 |
| 4 | UART |
| 5 | timer 2, the OR of its overflow flag and its external flag |
| 6 | I2C event |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_req`, `clr_pulse`, `svc_hi` and `svc_lo` are all 0.
- R2: A flag can only win when its bit in `src_en` is 1 and `glb_en` is 1. A pending flag whose own enable or the global enable is 0 never raises `irq_req`.
- R3: If eligible requests of both levels are present in the same captured set, the one whose `src_hi` bit is 1 is chosen.
- R4: Among eligible requests of one level, the lowest bit index wins. The bit order is the one given in the table above.
- R5: `irq_vec` equals 0x03 + 8 × (index of the winner): 0x03, 0x0B, 0x13, 0x1B, 0x23, 0x2B, 0x33 for bits 0 to 6. It stays stable while `irq_req` is held.
- R6: Flags are captured on each clock where `mc_strobe` is 1, and arbitration uses that copy at the next strobe. A flag raised just after a strobe therefore raises `irq_req` after the second strobe. A flag that falls before the block is unblocked is never serviced.
- R7: While only `svc_lo` is set, a low-level request is not issued and a high-level request is issued. Taking the high-level request leaves both `svc_hi` and `svc_lo` set.
- R8: While `svc_hi` is set, no request of either level is issued.
- R9: When `vec_taken` is 1 while `irq_req` is 1, `irq_req` falls on the next clock. The in-service bit of the taken request's level (`svc_hi` or `svc_lo`) is set.
- R10: A `reti` pulse clears `svc_hi` if it is set. Otherwise it clears `svc_lo`.
- R11: On the clock after a take, `clr_pulse` is high for exactly one clock, on the taken source's bit only. This happens for bit 1 and bit 3 always, for bit 0 when `ext_edge[0]` is 1, and for bit 2 when `ext_edge[1]` is 1. No clear pulse is produced for any other source or mode.
- R12: No request is issued at a strobe that closes a machine cycle in which `reti` or `cfg_wr` was pulsed. Arbitration resumes at the strobe after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_strobe | input | 1 | One-clock pulse per machine cycle: flag capture and arbitration point |
| req_flags | input | 7 | Request flags in polling order |
| ext_edge | input | 2 | 1 = external request 0/1 is edge-mode (hardware-cleared on take) |
| src_en | input | 7 | Per-source enable |
| glb_en | input | 1 | Global enable |
| src_hi | input | 7 | Per-source level, 1 = high |
| cfg_wr | input | 1 | Pulse marking a write to the enable or priority settings |
| vec_taken | input | 1 | Core has taken the vector |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Request to the core |
| irq_vec | output | 8 | Vector address of the pending request |
| clr_pulse | output | 7 | One-clock hardware clear of the taken flag |
| svc_hi | output | 1 | High-level routine in service |
| svc_lo | output | 1 | Low-level routine in service |

## Verification
A return pulse or a settings write can fall in the same machine cycle as a strobe that would otherwise issue a waiting request. The bench lines up `reti` or `cfg_wr` just after a strobe, while a lower-level flag is already captured and eligible. It then checks that `irq_req` stays low after the next strobe and rises after the one after it. The scoreboard rejects any request that appears early, which judges the hold-off and the release of the nesting level together.

// File: rtl/irqc_pkg.sv
// Shared defaults, source indices and the level type for the interrupt arbiter.
package irqc_pkg;
    localparam int DEF_NSRC     = 7;
    localparam int DEF_VEC_W    = 8;
    localparam int DEF_VEC_BASE = 3;
    localparam int DEF_VEC_STEP = 8;

    // Polling positions whose flags hardware may clear on take
    localparam int IDX_EXT0 = 0;
    localparam int IDX_TMR0 = 1;
    localparam int IDX_EXT1 = 2;
    localparam int IDX_TMR1 = 3;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;
endpackage

// File: rtl/irqc_sample.sv
// Captures the request flags at each machine-cycle strobe and raises a
// hold-off flag for the rest of any machine cycle that saw a return pulse
// or a settings write.
// Assumes mc_strobe is a single-clock pulse.
module irqc_sample #(
    parameter int NSRC = irqc_pkg::DEF_NSRC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_strobe,
    input  logic [NSRC-1:0] flags_in,
    input  logic            reti,
    input  logic            cfg_wr,
    output logic [NSRC-1:0] snap,
    output logic            issue_block
);
    logic hold_q;

    // Flag capture point, once per machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)         snap <= '0;
        else if (mc_strobe) snap <= flags_in;
    end

    // Hold-off remembered until the strobe that closes the machine cycle
    always_ff @(posedge clk) begin
        if (!rst_n)               hold_q <= 1'b0;
        else if (mc_strobe)       hold_q <= 1'b0;
        else if (reti || cfg_wr)  hold_q <= 1'b1;
    end

    assign issue_block = hold_q | reti | cfg_wr;

    // R6
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_strobe |=> $stable(snap));
endmodule

// File: rtl/irqc_select.sv
// Combinational two-level arbiter over the captured flags. It applies the
// masks and the in-service blocking, then prefers the high level and, within
// a level, the lowest index.
// Assumes bit order equals polling order.
module irqc_select #(
    parameter int NSRC  = irqc_pkg::DEF_NSRC,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic             [NSRC-1:0]  snap,
    input  logic             [NSRC-1:0]  src_en,
    input  logic                         glb_en,
    input  logic             [NSRC-1:0]  src_hi,
    input  logic                         svc_hi,
    input  logic                         svc_lo,
    output logic                         win_valid,
    output irqc_pkg::lvl_e               win_lvl,
    output logic             [IDX_W-1:0] win_idx
);
    logic [NSRC-1:0] live, hi_set, lo_set, pick_set;

    assign live   = snap & src_en & {NSRC{glb_en}};
    assign hi_set = live & src_hi & {NSRC{!svc_hi}};
    assign lo_set = live & ~src_hi & {NSRC{!(svc_hi || svc_lo)}};

    // Level choice then fixed-order scan, lowest index last so it wins
    always_comb begin
        win_lvl   = (|hi_set) ? irqc_pkg::LVL_HI : irqc_pkg::LVL_LO;
        pick_set  = (|hi_set) ? hi_set : lo_set;
        win_valid = |pick_set;
        win_idx   = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pick_set[i]) win_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irqc_nest.sv
// Two in-service bits, one per level. A take sets the bit of its level, and
// a return clears the high bit if set, otherwise the low bit.
// Assumes at most one take per clock.
module irqc_nest (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           take,
    input  irqc_pkg::lvl_e take_lvl,
    input  logic           reti,
    output logic           svc_hi,
    output logic           svc_lo
);
    logic hi_n, lo_n;

    // Next nesting state: unwind first, then record the new entry
    always_comb begin
        hi_n = svc_hi;
        lo_n = svc_lo;
        if (reti) begin
            if (svc_hi) hi_n = 1'b0;
            else        lo_n = 1'b0;
        end
        if (take) begin
            if (take_lvl == irqc_pkg::LVL_HI) hi_n = 1'b1;
            else                              lo_n = 1'b1;
        end
    end

    // In-service registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_hi <= 1'b0;
            svc_lo <= 1'b0;
        end else begin
            svc_hi <= hi_n;
            svc_lo <= lo_n;
        end
    end

    // R10
    reti_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti && svc_hi && !take |=> !svc_hi && (svc_lo == $past(svc_lo)));
    // R10
    reti_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reti && !svc_hi && !take |=> !svc_lo);
    // R8
    hi_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !svc_hi);
    // R7
    lo_no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && take_lvl == irqc_pkg::LVL_LO |-> !svc_lo);
endmodule

// File: rtl/prio_irq_ctrl.sv
// Top of the two-level interrupt arbiter. It issues a held request with a
// vector at a machine-cycle strobe, completes it on the core's take, pulses
// the hardware-clear for the taken flag, and tracks nesting.
// Assumes vec_taken is only raised while irq_req is high.
module prio_irq_ctrl #(
    parameter int NSRC     = irqc_pkg::DEF_NSRC,
    parameter int VEC_W    = irqc_pkg::DEF_VEC_W,
    parameter int VEC_BASE = irqc_pkg::DEF_VEC_BASE,
    parameter int VEC_STEP = irqc_pkg::DEF_VEC_STEP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_strobe,
    input  logic [NSRC-1:0]  req_flags,
    input  logic [1:0]       ext_edge,
    input  logic [NSRC-1:0]  src_en,
    input  logic             glb_en,
    input  logic [NSRC-1:0]  src_hi,
    input  logic             cfg_wr,
    input  logic             vec_taken,
    input  logic             reti,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec,
    output logic [NSRC-1:0]  clr_pulse,
    output logic             svc_hi,
    output logic             svc_lo
);
    localparam int IDX_W = $clog2(NSRC);

    logic [NSRC-1:0]  snap;
    logic             issue_block;
    logic             win_valid;
    irqc_pkg::lvl_e   win_lvl;
    logic [IDX_W-1:0] win_idx;
    logic [IDX_W-1:0] cur_idx;
    irqc_pkg::lvl_e   cur_lvl;
    logic [NSRC-1:0]  hw_clr_mask;
    logic [NSRC-1:0]  cur_onehot;
    logic             issue, take;

    irqc_sample #(.NSRC(NSRC)) u_sample (
        .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .flags_in(req_flags),
        .reti(reti), .cfg_wr(cfg_wr), .snap(snap), .issue_block(issue_block)
    );

    irqc_select #(.NSRC(NSRC), .IDX_W(IDX_W)) u_select (
        .snap(snap), .src_en(src_en), .glb_en(glb_en), .src_hi(src_hi),
        .svc_hi(svc_hi), .svc_lo(svc_lo),
        .win_valid(win_valid), .win_lvl(win_lvl), .win_idx(win_idx)
    );

    irqc_nest u_nest (
        .clk(clk), .rst_n(rst_n), .take(take), .take_lvl(cur_lvl),
        .reti(reti), .svc_hi(svc_hi), .svc_lo(svc_lo)
    );

    // Which sources hardware clears on take
    for (genvar g = 0; g < NSRC; g++) begin : g_clr
        if (g == irqc_pkg::IDX_TMR0 || g == irqc_pkg::IDX_TMR1) begin : g_tmr
            assign hw_clr_mask[g] = 1'b1;
        end else if (g == irqc_pkg::IDX_EXT0) begin : g_ext0
            assign hw_clr_mask[g] = ext_edge[0];
        end else if (g == irqc_pkg::IDX_EXT1) begin : g_ext1
            assign hw_clr_mask[g] = ext_edge[1];
        end else begin : g_sw
            assign hw_clr_mask[g] = 1'b0;
        end
    end

    assign issue      = mc_strobe && !issue_block && !irq_req && win_valid;
    assign take       = irq_req && vec_taken;
    assign cur_onehot = NSRC'(1) << cur_idx;

    // Pending request register with its vector and origin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
            cur_idx <= '0;
            cur_lvl <= irqc_pkg::LVL_LO;
        end else if (take) begin
            irq_req <= 1'b0;
        end else if (issue) begin
            irq_req <= 1'b1;
            irq_vec <= VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx));
            cur_idx <= win_idx;
            cur_lvl <= win_lvl;
        end
    end

    // One-clock hardware clear of the taken flag
    always_ff @(posedge clk) begin
        if (!rst_n)    clr_pulse <= '0;
        else if (take) clr_pulse <= cur_onehot & hw_clr_mask;
        else           clr_pulse <= '0;
    end

    // R6
    rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(mc_strobe));
    // R12
    hold_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> !$past(issue_block));
    // R2
    glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(glb_en));
    // R9
    take_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && vec_taken |=> !irq_req);
    // R5
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && !vec_taken |=> irq_req && $stable(irq_vec));
    // R11
    clr_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |clr_pulse |-> $past(irq_req && vec_taken));
    // R11
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_pulse));
endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
    localparam int NSRC = 7;

    typedef struct {
        logic [7:0]      vec;
        logic [NSRC-1:0] clr;
        string           tag;
    } exp_t;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic            rst_n, mc_strobe, glb_en, cfg_wr, vec_taken, reti;
    logic [NSRC-1:0] req_flags, src_en, src_hi, clr_pulse;
    logic [1:0]      ext_edge;
    logic            irq_req, svc_hi, svc_lo;
    logic [7:0]      irq_vec;

    int   errors = 0;
    int   checks = 0;
    exp_t exp_q[$];

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe), .req_flags(req_flags),
        .ext_edge(ext_edge), .src_en(src_en), .glb_en(glb_en), .src_hi(src_hi),
        .cfg_wr(cfg_wr), .vec_taken(vec_taken), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .clr_pulse(clr_pulse),
        .svc_hi(svc_hi), .svc_lo(svc_lo)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Machine-cycle strobe: one clock in four
    initial begin
        int cnt = 0;
        mc_strobe = 1'b0;
        forever begin
            @(negedge clk);
            cnt       = rst_n ? (cnt + 1) % 4 : 0;
            mc_strobe = rst_n && (cnt == 3);
        end
    end

    // Monitor: pops the expected item for each request, takes it, checks the clear
    initial begin
        vec_taken = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && irq_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected request", int'(irq_vec), 0);
                    vec_taken = 1'b1;
                    @(negedge clk);
                    vec_taken = 1'b0;
                end else begin
                    exp_t it;
                    it = exp_q.pop_front();
                    check(irq_vec == it.vec, {it.tag, " R5 vector"}, int'(irq_vec), int'(it.vec));
                    vec_taken = 1'b1;
                    @(negedge clk);
                    vec_taken = 1'b0;
                    check(clr_pulse == it.clr, {it.tag, " R11 clear"}, int'(clr_pulse), int'(it.clr));
                    check(!irq_req, "R9 request dropped", int'(irq_req), 0);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic push(input logic [7:0] v, input logic [NSRC-1:0] c, input string t);
        exp_t it;
        it.vec = v; it.clr = c; it.tag = t;
        exp_q.push_back(it);
    endtask

    task automatic strobe_edge();
        do @(posedge clk); while (!mc_strobe);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        for (int i = 0; i < n; i++) strobe_edge();
    endtask

    task automatic wait_taken();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg(input logic [NSRC-1:0] en, input logic g,
                       input logic [NSRC-1:0] hi, input logic [1:0] ed);
        src_en = en; glb_en = g; src_hi = hi; ext_edge = ed;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; req_flags = '0; src_en = '0; glb_en = 1'b0; src_hi = '0;
        ext_edge = '0; cfg_wr = 1'b0; reti = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!irq_req && !svc_hi && !svc_lo && clr_pulse == '0, "R1 reset state",
              {irq_req, svc_hi, svc_lo}, 0);

        // R2 enable gating (timer 1)
        req_flags[3] = 1'b1;
        cfg(7'h00, 1'b1, 7'h00, 2'b00);
        settle(3);
        check(!irq_req && !svc_lo, "R2 own enable off", int'(irq_req), 0);
        cfg(7'h7f, 1'b0, 7'h00, 2'b00);
        settle(3);
        check(!irq_req && !svc_lo, "R2 global enable off", int'(irq_req), 0);
        push(8'h1B, 7'b0001000, "R2 enabled timer1");
        cfg(7'h7f, 1'b1, 7'h00, 2'b00);
        wait_taken();
        check(svc_lo && !svc_hi, "R9 low level entered", {svc_hi, svc_lo}, 1);
        req_flags[3] = 1'b0;
        do_reti();
        check(!svc_lo, "R10 return clears low", int'(svc_lo), 0);

        // R4 polling order within the low level
        req_flags[6:4] = 3'b111;
        push(8'h23, 7'b0, "R4 uart first");
        wait_taken();
        req_flags[4] = 1'b0;
        push(8'h2B, 7'b0, "R4 timer2 second");
        do_reti();
        wait_taken();
        req_flags[5] = 1'b0;
        push(8'h33, 7'b0, "R4 i2c third");
        do_reti();
        wait_taken();
        req_flags[6] = 1'b0;
        do_reti();
        check(!svc_lo && !svc_hi, "R10 all unwound", {svc_hi, svc_lo}, 0);

        // R3 high wins over low; R8 nothing during high service
        cfg(7'h7f, 1'b1, 7'b1000000, 2'b00);
        req_flags[2] = 1'b1;
        req_flags[6] = 1'b1;
        push(8'h33, 7'b0, "R3 high i2c wins");
        wait_taken();
        check(svc_hi && !svc_lo, "R9 high level entered", {svc_hi, svc_lo}, 2);
        settle(3);
        check(!irq_req, "R8 low held during high", int'(irq_req), 0);
        req_flags[6] = 1'b0;
        push(8'h13, 7'b0, "R11 level ext1 not cleared");
        do_reti();
        wait_taken();
        check(!svc_hi && svc_lo, "R10 high cleared then low taken", {svc_hi, svc_lo}, 1);
        req_flags[2] = 1'b0;
        do_reti();

        // R7 preemption of low by high, low not nested under low
        cfg(7'h7f, 1'b1, 7'b0000001, 2'b01);
        req_flags[4] = 1'b1;
        push(8'h23, 7'b0, "R7 uart low");
        wait_taken();
        req_flags[3] = 1'b1;
        settle(3);
        check(!irq_req, "R7 low blocked under low", int'(irq_req), 0);
        req_flags[0] = 1'b1;
        push(8'h03, 7'b0000001, "R7 R11 edge ext0 preempts");
        wait_taken();
        req_flags[0] = 1'b0;
        check(svc_hi && svc_lo, "R7 both levels active", {svc_hi, svc_lo}, 3);
        settle(2);
        do_reti();
        check(!svc_hi && svc_lo, "R10 high first", {svc_hi, svc_lo}, 1);
        settle(3);
        check(!irq_req, "R7 low still blocked", int'(irq_req), 0);
        req_flags[4] = 1'b0;
        push(8'h1B, 7'b0001000, "R7 timer1 after return");
        do_reti();
        wait_taken();
        req_flags[3] = 1'b0;
        do_reti();

        // R6 a blocked request that goes away is forgotten
        cfg(7'h7f, 1'b1, 7'b1000000, 2'b00);
        req_flags[6] = 1'b1;
        push(8'h33, 7'b0, "R6 high i2c");
        wait_taken();
        req_flags[1] = 1'b1;
        settle(2);
        req_flags[1] = 1'b0;
        req_flags[6] = 1'b0;
        do_reti();
        settle(4);
        check(!irq_req && !svc_hi && !svc_lo, "R6 dropped request forgotten",
              {irq_req, svc_hi, svc_lo}, 0);

        // R6 latency: capture then arbitrate one strobe later
        cfg(7'h7f, 1'b1, 7'h00, 2'b00);
        strobe_edge();
        req_flags[1] = 1'b1;
        push(8'h0B, 7'b0000010, "R6 timer0 latency");
        strobe_edge();
        check(!irq_req, "R6 not after first strobe", int'(irq_req), 0);
        strobe_edge();
        check(irq_req, "R6 request after second strobe", int'(irq_req), 1);
        wait_taken();
        req_flags[1] = 1'b0;
        do_reti();

        // R12 return pulse holds off the next strobe
        req_flags[4] = 1'b1;
        push(8'h23, 7'b0, "R12 uart");
        wait_taken();
        req_flags[3] = 1'b1;
        req_flags[4] = 1'b0;
        settle(2);
        strobe_edge();
        do_reti();
        push(8'h1B, 7'b0001000, "R12 timer1 after return");
        strobe_edge();
        check(!irq_req, "R12 return holds off strobe", int'(irq_req), 0);
        strobe_edge();
        check(irq_req, "R12 resumes next strobe", int'(irq_req), 1);
        wait_taken();
        req_flags[3] = 1'b0;
        do_reti();

        // R12 settings write holds off the next strobe
        cfg(7'b1011111, 1'b1, 7'h00, 2'b00);
        req_flags[5] = 1'b1;
        settle(2);
        check(!irq_req, "R2 timer2 masked", int'(irq_req), 0);
        strobe_edge();
        push(8'h2B, 7'b0, "R12 timer2 after write");
        cfg(7'h7f, 1'b1, 7'h00, 2'b00);
        strobe_edge();
        check(!irq_req, "R12 write holds off strobe", int'(irq_req), 0);
        strobe_edge();
        check(irq_req, "R12 resumes after write", int'(irq_req), 1);
        wait_taken();
        req_flags[5] = 1'b0;
        do_reti();
        settle(2);
        check(exp_q.size() == 0, "R5 all expected requests seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule